// File: doc/BRIEF.md
# Complementary PWM Pin Stage with Brake

This block sits between a PWM timer and the pads of a motor bridge. It takes three raw, positive-logic PWM waveforms and turns them into six pin drives arranged as three pairs. Each pair has its own mode. In complementary mode, the low-side pin carries the inverse of the high-side pin, and a programmable dead band keeps both transistors of a leg from conducting at the same time. In in-phase mode, both pins follow the same waveform.

After the pair stage, each pin passes through its own override and its own inversion. The override replaces the PWM value with a fixed level, for block-commutation of a brushless motor. The inversion adapts the pin to active-high or active-low gate drivers. Every pin has an output enable. The enables are low during reset and whenever a hardware brake has been latched. A tri-stated pin also drives a value of 0.

The brake input passes through a two-stage synchronizer and then sets a sticky fault flag, which is presented as an interrupt request. Software clears the flag with a clear strobe. The strobe has no effect while the synchronized brake is still asserted.

Top module: `pwm_pin_stage`

## Requirements
- R1: After a synchronous reset, all `pin_out` bits are 0, all `pin_oe` bits are 0, and `brake_irq` is 0.
- R2: Pair p drives pin 2p (high side) and pin 2p+1 (low side). In complementary mode (`pair_comp[p]`=1), the high side is active only while `raw_pwm[p]` has been sampled high on more than `dead_time` consecutive edges. The low side is active only while `raw_pwm[p]` has been sampled low on more than `dead_time` consecutive edges. The two sides are never active together. A pin changes on the second rising edge after the raw input that causes the change.
- R3: In complementary mode, a raw high or low pulse that lasts `dead_time` cycles or fewer produces no active level on the corresponding pin.
- R4: In in-phase mode (`pair_comp[p]`=0), both pins of the pair carry the raw level with no dead band, and `dead_time` has no effect.
- R5: With `dead_time`=0, a complementary pair is an exact inverse pair with no delay beyond the fixed pipeline.
- R6: When `mask_en[i]`=1, pin i carries `mask_val[i]` in place of its PWM value.
- R7: When `pol_inv[i]`=1, the value of pin i is inverted. The inversion is applied after the mask override.
- R8: Once `brake_irq` is high, on the following edge every `pin_oe` bit goes to 0 and every `pin_out` bit goes to 0.
- R9: The brake flag stays set until `brake_clr` is sampled high while the synchronized brake is low. A clear that arrives while the brake is still present is ignored.
- R10: `brake_irq` rises on the third rising edge that samples `brake_in` high, counting the first such edge as one. This holds even for a single-cycle brake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_pwm | input | NPAIR | Positive-logic PWM waveform for each pair |
| pair_comp | input | NPAIR | 1 = complementary with dead band, 0 = in-phase |
| dead_time | input | DTW | Dead band in clock cycles, shared by all pairs |
| mask_en | input | 2*NPAIR | Per-pin override enable |
| mask_val | input | 2*NPAIR | Per-pin override level |
| pol_inv | input | 2*NPAIR | Per-pin output inversion |
| brake_in | input | 1 | Asynchronous hardware brake request |
| brake_clr | input | 1 | Strobe that clears the latched brake |
| pin_out | output | 2*NPAIR | Pin drive values |
| pin_oe | output | 2*NPAIR | Pin output enables (0 = tri-state) |
| brake_irq | output | 1 | Latched brake interrupt request |

## Verification
The most delicate collision is a brake that lands while the pins are mid-pattern, with the dead band counting and the overrides and inversions active. The bench injects brake pulses during live complementary activity. The reference model then decides, cycle by cycle, the exact edge on which the enables drop and the values fall to 0. The second collision is a clear strobe on the same edge as a still-present synchronized brake. The bench holds `brake_in` high while pulsing `brake_clr` and checks that the flag survives. It then releases the brake and pulses the clear again, and checks that the pins come back on the expected edge.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
  typedef enum logic {
    PAIR_INPHASE = 1'b0,
    PAIR_COMPL   = 1'b1
  } pair_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } pair_drive_t;
endpackage

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raw,
  input  logic           comp,
  input  logic [DTW-1:0] dt,
  output pwm_pin_pkg::pair_drive_t drive
);
  import pwm_pin_pkg::*;

  localparam int CW = DTW + 1;
  localparam logic [CW-1:0] RUN_MAX = '1;

  logic          level_q;
  logic [CW-1:0] run_q;
  logic          settled;
  pair_mode_e    mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (raw != level_q) begin
      level_q <= raw;
      run_q   <= {{(CW-1){1'b0}}, 1'b1};
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_comb begin
    mode    = pair_mode_e'(comp);
    settled = run_q > {1'b0, dt};
    if (mode == PAIR_COMPL) begin
      drive.hi = level_q & settled;
      drive.lo = ~level_q & settled;
    end else begin
      drive.hi = level_q;
      drive.lo = level_q;
    end
  end

  // R2: the two sides of a complementary pair are never active together.
  p_sides_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    comp |-> !(drive.hi && drive.lo));
endmodule

// File: rtl/pwm_brake_ctl.sv
module pwm_brake_ctl (
  input  logic clk,
  input  logic rst,
  input  logic brake_in,
  input  logic brake_clr,
  output logic fault
);
  logic sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      fault   <= 1'b0;
    end else begin
      sync1_q <= brake_in;
      sync2_q <= sync1_q;
      if (sync2_q)        fault <= 1'b1;
      else if (brake_clr) fault <= 1'b0;
    end
  end

  p_set_on_brake_r10: assert property (@(posedge clk) disable iff (rst)
    sync2_q |=> fault);

  p_fault_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (fault && !brake_clr) |=> fault);
endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pwm,
  input  logic mask_en,
  input  logic mask_val,
  input  logic pol_inv,
  input  logic fault,
  output logic pin,
  output logic oe
);
  logic chosen;

  always_comb chosen = mask_en ? mask_val : pwm;

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      pin <= 1'b0;
      oe  <= 1'b0;
    end else begin
      pin <= chosen ^ pol_inv;
      oe  <= 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pin && !oe));
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
  parameter int NPAIR = 3,
  parameter int DTW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPAIR-1:0]     raw_pwm,
  input  logic [NPAIR-1:0]     pair_comp,
  input  logic [DTW-1:0]       dead_time,
  input  logic [2*NPAIR-1:0]   mask_en,
  input  logic [2*NPAIR-1:0]   mask_val,
  input  logic [2*NPAIR-1:0]   pol_inv,
  input  logic                 brake_in,
  input  logic                 brake_clr,
  output logic [2*NPAIR-1:0]   pin_out,
  output logic [2*NPAIR-1:0]   pin_oe,
  output logic                 brake_irq
);
  import pwm_pin_pkg::*;

  localparam int NPIN = 2 * NPAIR;

  logic [NPIN-1:0] pos_pwm;
  logic            fault;

  pwm_brake_ctl u_brake (
    .clk      (clk),
    .rst      (rst),
    .brake_in (brake_in),
    .brake_clr(brake_clr),
    .fault    (fault)
  );

  assign brake_irq = fault;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_drive_t drv;

    pwm_deadband #(.DTW(DTW)) u_db (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_pwm[p]),
      .comp (pair_comp[p]),
      .dt   (dead_time),
      .drive(drv)
    );

    assign pos_pwm[2*p]   = drv.hi;
    assign pos_pwm[2*p+1] = drv.lo;

    // R2: pins of an unmodified complementary pair never both high.
    p_pins_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
      $past(pair_comp[p] & ~mask_en[2*p] & ~mask_en[2*p+1]
            & ~pol_inv[2*p] & ~pol_inv[2*p+1])
      |-> !(pin_out[2*p] && pin_out[2*p+1]));
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pwm_pin_ctl u_pin (
      .clk     (clk),
      .rst     (rst),
      .pwm     (pos_pwm[i]),
      .mask_en (mask_en[i]),
      .mask_val(mask_val[i]),
      .pol_inv (pol_inv[i]),
      .fault   (fault),
      .pin     (pin_out[i]),
      .oe      (pin_oe[i])
    );
  end

  p_brake_tristate_r8: assert property (@(posedge clk) disable iff (rst)
    brake_irq |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/test_pwm_pin_stage.sv
module test_pwm_pin_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 3;
  localparam int NPIN  = 6;
  localparam int DTW   = 8;
  localparam int RUN_MAX = 511;

  logic clk = 0;
  logic rst = 1;
  logic [NPAIR-1:0] raw_pwm = '0;
  logic [NPAIR-1:0] pair_comp = '1;
  logic [DTW-1:0]   dead_time = '0;
  logic [NPIN-1:0]  mask_en = '0, mask_val = '0, pol_inv = '0;
  logic brake_in = 0, brake_clr = 0;
  logic [NPIN-1:0] pin_out, pin_oe;
  logic brake_irq;

  int n_tests = 0, n_fail = 0;
  string tag = "R1";
  bit checking = 0;

  pwm_pin_stage #(.NPAIR(NPAIR), .DTW(DTW)) i_pwm_pin_stage (
    .clk(clk), .rst(rst), .raw_pwm(raw_pwm), .pair_comp(pair_comp),
    .dead_time(dead_time), .mask_en(mask_en), .mask_val(mask_val),
    .pol_inv(pol_inv), .brake_in(brake_in), .brake_clr(brake_clr),
    .pin_out(pin_out), .pin_oe(pin_oe), .brake_irq(brake_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: history of how long each raw input has held.
  int  held[NPAIR];
  bit  last[NPAIR];
  bit  seen1, seen2, flag;
  logic [NPIN-1:0] m_out = '0, m_oe = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPAIR; p++) begin held[p] = 0; last[p] = 0; end
      seen1 = 0; seen2 = 0; flag = 0; m_out = '0; m_oe = '0;
    end else begin
      for (int p = 0; p < NPAIR; p++) begin
        bit hi, lo, ok;
        ok = held[p] > int'(dead_time);
        if (pair_comp[p]) begin hi = last[p] && ok; lo = !last[p] && ok; end
        else begin hi = last[p]; lo = last[p]; end
        for (int s = 0; s < 2; s++) begin
          int i;
          bit v;
          i = 2*p + s;
          v = (s == 0) ? hi : lo;
          if (mask_en[i]) v = mask_val[i];
          m_out[i] = flag ? 1'b0 : (v ^ pol_inv[i]);
          m_oe[i]  = !flag;
        end
      end
      for (int p = 0; p < NPAIR; p++) begin
        if (raw_pwm[p] != last[p]) begin last[p] = raw_pwm[p]; held[p] = 1; end
        else if (held[p] < RUN_MAX) held[p] = held[p] + 1;
      end
      if (seen2) flag = 1;
      else if (brake_clr) flag = 0;
      seen2 = seen1;
      seen1 = brake_in;
    end
  end

  task automatic tick();
    @(negedge clk);
    if (checking) begin
      n_tests++;
      if (pin_out !== m_out || pin_oe !== m_oe || brake_irq !== flag) begin
        n_fail++;
        $display("FAIL %s: out=%b oe=%b irq=%b expected out=%b oe=%b irq=%b",
                 tag, pin_out, pin_oe, brake_irq, m_out, m_oe, flag);
      end
    end
  endtask

  task automatic run_pattern(int n, int p0, int p1, int p2);
    for (int k = 0; k < n; k++) begin
      tick();
      raw_pwm[0] = (k % p0) < (p0 / 2);
      raw_pwm[1] = ((k + 3) % p1) < (p1 / 2);
      raw_pwm[2] = (k % p2) < (p2 / 3 + 1);
    end
  endtask

  task automatic pulse0(int len, int gap);
    raw_pwm[0] = 1;
    repeat (len) tick();
    raw_pwm[0] = 0;
    repeat (gap) tick();
  endtask

  initial begin
    repeat (3) tick();
    checking = 1;
    tag = "R1"; repeat (2) tick();
    rst = 0;
    tag = "R2"; dead_time = 3; pair_comp = 3'b111;
    run_pattern(70, 16, 10, 22);
    tag = "R3"; dead_time = 4; raw_pwm = '0; repeat (6) tick();
    pulse0(2, 6); pulse0(4, 6); pulse0(5, 3); pulse0(9, 2); pulse0(1, 8);
    tag = "R5"; dead_time = 0; run_pattern(30, 4, 2, 6);
    tag = "R4"; dead_time = 5; pair_comp = 3'b000; run_pattern(30, 6, 4, 8);
    tag = "R2"; dead_time = 2; pair_comp = 3'b101; run_pattern(30, 8, 6, 12);
    tag = "R6"; pair_comp = 3'b111; mask_en = 6'b100101; mask_val = 6'b000100;
    run_pattern(25, 8, 6, 10);
    mask_val = 6'b100001; run_pattern(10, 8, 6, 10);
    tag = "R7"; pol_inv = 6'b110011; run_pattern(25, 8, 6, 10);
    mask_en = '0; run_pattern(20, 8, 6, 10);
    tag = "R10"; brake_in = 1; tick(); brake_in = 0;
    run_pattern(3, 8, 6, 10);
    tag = "R8"; run_pattern(10, 8, 6, 10);
    tag = "R9"; brake_in = 1; brake_clr = 1; run_pattern(4, 8, 6, 10);
    brake_clr = 0; run_pattern(4, 8, 6, 10);
    brake_in = 0; brake_clr = 1; tick(); brake_clr = 0;
    run_pattern(4, 8, 6, 10);
    brake_clr = 1; tick(); brake_clr = 0;
    run_pattern(15, 8, 6, 10);
    tag = "R8"; pol_inv = '1; brake_in = 1; repeat (2) tick(); brake_in = 0;
    run_pattern(8, 8, 6, 10);
    brake_clr = 1; tick(); brake_clr = 0; run_pattern(8, 8, 6, 10);
    tag = "R1"; rst = 1; repeat (3) tick(); rst = 0; pol_inv = '0;
    tag = "R2"; run_pattern(12, 8, 6, 10);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule